// File: doc/BRIEF.md
# Flash Erase-Block Select Registers

This block is a small set of byte-wide registers on a local register bus. It records which one of ten flash blocks may be erased, and it guards the bit that readies the flash for programming. Software writes a block choice into one of two selection registers. The block keeps at most one block bit set across both registers. It drives a one-hot erase enable toward the flash array only while the hardware write-enable pin and the software write-enable bit are both high and the on-chip flash is enabled.

A third register holds the program-setup bit and a sticky error flag. The program-setup bit can be set only while both write enables are high. A write that asks for program setup together with any other flash mode bit is refused and sets the error flag. The selection is cleared on reset, in either standby mode, and whenever either write enable is low. When the flash is disabled, every register reads as zero and ignores writes.

Top module: `erase_sel_regs`

## Requirements
- R1: Address 1 bits 7..0 hold blocks 7..0. Address 0 bits 1..0 hold blocks 9..8. The byte at `reg_addr` appears on `reg_rdata` one clock after the address is presented.
- R2: Bits 7..2 at address 0 always read 0, and writes to those bits are ignored.
- R3: After reset, every register reads 0x00, `erase_en` is 0 and `prog_setup` is 0.
- R4: A high level on `hw_standby` or `sw_standby` clears the whole block selection.
- R5: While `hw_wr_en` or `sw_wr_en` is low, the selection is held at zero. A selection write in that state has no effect.
- R6: A write that would leave more than one block bit set across addresses 0 and 1 is discarded whole, and the previous selection is kept. At most one block bit is ever set.
- R7: `erase_en` equals the ten-bit selection {addr0[1:0], addr1[7:0]}, forced to zero unless `hw_wr_en`=1, `sw_wr_en`=1 and `flash_off`=0. It is registered one clock after the selection or the qualifier changes.
- R8: While `flash_off` is 1, every read returns 0x00 and register writes have no effect.
- R9: Address 2 bit 0 is the program-setup bit, mirrored on `prog_setup`. A write stores bit 0 only while `hw_wr_en`=1 and `sw_wr_en`=1. The bit clears when either write enable is low, in standby, and on reset.
- R10: A write to address 2 with bit 0 = 1 and any of bits 6..1 (the other mode bits) set leaves `prog_setup` unchanged and sets the error flag at address 2 bit 7.
- R11: The error flag stays set until a write to address 2 with bit 7 = 1 that is not itself a violation. Such a write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address (0 upper select, 1 lower select, 2 control) |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| hw_wr_en | input | 1 | Hardware flash write-enable pin level |
| sw_wr_en | input | 1 | Software write-enable bit |
| hw_standby | input | 1 | Hardware standby indicator |
| sw_standby | input | 1 | Software standby indicator |
| flash_off | input | 1 | On-chip flash disabled |
| erase_en | output | 10 | One-hot erase-block enable |
| prog_setup | output | 1 | Program-setup flag |

## Verification
The assertions check several rules on every cycle. They confirm that at most one erase bit is ever set. They confirm that the selection is empty after any clearing condition and that `erase_en` falls to zero whenever the qualifier is low. They also cover the rules that flash-off reads return zero, that program setup rises only under both write enables, that a mode-conflict write leaves program setup unchanged and sets the error flag, and that the flag stays set. The bench scenarios are needed for the register address map and field positions, the reserved bits, discarding a multi-bit write while the old selection stays, and recovering the old selection after the flash comes back on. They are also needed for the ordering of write-one-to-clear against a new violation.

// File: rtl/ers_pkg.sv
package ers_pkg;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_SEL_HI = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd2;

  // control register field positions
  localparam int unsigned CTL_SETUP_BIT = 0;
  localparam int unsigned CTL_MODE_LO   = 1;
  localparam int unsigned CTL_MODE_HI   = 6;
  localparam int unsigned CTL_ERR_BIT   = 7;
endpackage

// File: rtl/ers_block_sel.sv
module ers_block_sel #(
  parameter int unsigned NUM_BLOCKS = 10,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_req,
  input  logic                  wr_hi,
  input  logic                  wr_lo,
  input  logic [DATA_W-1:0]     wdata,
  output logic [NUM_BLOCKS-1:0] sel
);
  localparam int unsigned HI_W = NUM_BLOCKS - DATA_W;

  logic [NUM_BLOCKS-1:0] sel_q;
  logic [NUM_BLOCKS-1:0] cand;
  logic                  cand_ok;

  // merge the write into the current selection
  always_comb begin
    cand = sel_q;
    if (wr_hi) cand[NUM_BLOCKS-1:DATA_W] = wdata[HI_W-1:0];
    if (wr_lo) cand[DATA_W-1:0] = wdata;
  end

  // zero or one bit set: clearing the lowest set bit leaves nothing
  assign cand_ok = ((cand & (cand - NUM_BLOCKS'(1))) == '0);

  always_ff @(posedge clk) begin
    if (rst || clr_req) begin
      sel_q <= '0;
    end else if ((wr_hi || wr_lo) && cand_ok) begin
      sel_q <= cand;
    end
  end

  assign sel = sel_q;

  // R4 R5
  sel_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_req |=> (sel_q == '0));

  // R6
  multi_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_req && (wr_hi || wr_lo) && ($countones(cand) > 1)) |=> $stable(sel_q));

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_q));
endmodule

// File: rtl/ers_setup_ctl.sv
module ers_setup_ctl
  import ers_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_req,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              psu,
  output logic              err
);
  logic psu_q, err_q;
  logic viol;

  assign viol = wdata[CTL_SETUP_BIT] && (|wdata[CTL_MODE_HI:CTL_MODE_LO]);

  always_ff @(posedge clk) begin
    if (rst) begin
      psu_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      if (wr) begin
        if (viol)                   err_q <= 1'b1;
        else if (wdata[CTL_ERR_BIT]) err_q <= 1'b0;
      end
      if (clr_req)          psu_q <= 1'b0;
      else if (wr && !viol) psu_q <= wdata[CTL_SETUP_BIT];
    end
  end

  assign psu = psu_q;
  assign err = err_q;

  // R10
  excl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr && wdata[CTL_SETUP_BIT] && (wdata[CTL_MODE_HI:CTL_MODE_LO] != '0) && !clr_req)
      |=> ($stable(psu_q) && err_q));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_q && !(wr && wdata[CTL_ERR_BIT])) |=> err_q);
endmodule

// File: rtl/ers_rd_mux.sv
module ers_rd_mux
  import ers_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 10,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr,
  input  logic                  flash_off,
  input  logic [NUM_BLOCKS-1:0] sel,
  input  logic                  psu,
  input  logic                  err,
  output logic [DATA_W-1:0]     rdata
);
  localparam int unsigned HI_W = NUM_BLOCKS - DATA_W;

  logic [DATA_W-1:0] rd_next;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    rd_next = '0;
    if (!flash_off) begin
      unique case (addr)
        ADDR_SEL_HI: rd_next = {{(DATA_W-HI_W){1'b0}}, sel[NUM_BLOCKS-1:DATA_W]};
        ADDR_SEL_LO: rd_next = sel[DATA_W-1:0];
        ADDR_CTRL: begin
          rd_next[CTL_ERR_BIT]   = err;
          rd_next[CTL_SETUP_BIT] = psu;
        end
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/erase_sel_regs.sv
module erase_sel_regs
  import ers_pkg::*;
#(
  parameter int unsigned NUM_BLOCKS = 10,
  parameter int unsigned DATA_W     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic                  reg_we,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  input  logic                  hw_wr_en,
  input  logic                  sw_wr_en,
  input  logic                  hw_standby,
  input  logic                  sw_standby,
  input  logic                  flash_off,
  output logic [NUM_BLOCKS-1:0] erase_en,
  output logic                  prog_setup
);
  logic                  wr_ok;
  logic                  clr_req;
  logic                  qual;
  logic [NUM_BLOCKS-1:0] sel;
  logic                  psu, err;
  logic [NUM_BLOCKS-1:0] erase_q;

  assign wr_ok   = reg_we && !flash_off;
  assign clr_req = hw_standby || sw_standby || !hw_wr_en || !sw_wr_en;
  assign qual    = hw_wr_en && sw_wr_en && !flash_off;

  ers_block_sel #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) sel_i (
    .clk     (clk),
    .rst     (rst),
    .clr_req (clr_req),
    .wr_hi   (wr_ok && (reg_addr == ADDR_SEL_HI)),
    .wr_lo   (wr_ok && (reg_addr == ADDR_SEL_LO)),
    .wdata   (reg_wdata),
    .sel     (sel)
  );

  ers_setup_ctl #(.DATA_W(DATA_W)) ctl_i (
    .clk     (clk),
    .rst     (rst),
    .clr_req (clr_req),
    .wr      (wr_ok && (reg_addr == ADDR_CTRL)),
    .wdata   (reg_wdata),
    .psu     (psu),
    .err     (err)
  );

  ers_rd_mux #(.NUM_BLOCKS(NUM_BLOCKS), .DATA_W(DATA_W)) rd_i (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .flash_off (flash_off),
    .sel       (sel),
    .psu       (psu),
    .err       (err),
    .rdata     (reg_rdata)
  );

  // one gated enable register per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_erase
    always_ff @(posedge clk) begin
      if (rst) erase_q[b] <= 1'b0;
      else     erase_q[b] <= sel[b] && qual;
    end
  end

  assign erase_en   = erase_q;
  assign prog_setup = psu;

  // R7
  erase_qual_chk: assert property (@(posedge clk) disable iff (rst)
    !(hw_wr_en && sw_wr_en && !flash_off) |=> (erase_en == '0));

  // R6
  erase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(erase_en));

  // R8
  rd_off_chk: assert property (@(posedge clk) disable iff (rst)
    flash_off |=> (reg_rdata == '0));

  // R8
  wr_off_chk: assert property (@(posedge clk) disable iff (rst)
    (flash_off && !clr_req) |=> ($stable(sel) && $stable(psu)));

  // R9
  psu_guard_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_setup) |-> $past(hw_wr_en && sw_wr_en));
endmodule

// File: tb/erase_sel_regs_tb_top.sv
module erase_sel_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] reg_addr = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       hw_wr_en = 1'b0, sw_wr_en = 1'b0;
  logic       hw_standby = 1'b0, sw_standby = 1'b0, flash_off = 1'b0;
  logic [9:0] erase_en;
  logic       prog_setup;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  erase_sel_regs dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_wr_en(hw_wr_en), .sw_wr_en(sw_wr_en),
    .hw_standby(hw_standby), .sw_standby(sw_standby), .flash_off(flash_off),
    .erase_en(erase_en), .prog_setup(prog_setup)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
  endtask

  task automatic en_chk(input logic [9:0] exp, input string tag);
    @(negedge clk);
    chk(tag, erase_en, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R3 erase_en", erase_en, 10'h000);
    chk("R3 prog_setup", prog_setup, 1'b0);
    hw_wr_en = 1'b1; sw_wr_en = 1'b1;
    rd_chk(2'd0, 8'h00, "R3 addr0");
    rd_chk(2'd1, 8'h00, "R3 addr1");
    rd_chk(2'd2, 8'h00, "R3 addr2");
  endtask

  task automatic t_map();
    wr(2'd1, 8'h10);
    rd_chk(2'd1, 8'h10, "R1 lower block4");
    en_chk(10'h010, "R7 enable block4");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h02);
    rd_chk(2'd0, 8'h02, "R1 upper block9");
    en_chk(10'h200, "R7 enable block9");
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hFD);
    rd_chk(2'd0, 8'h01, "R2 reserved ignored");
    en_chk(10'h100, "R2 enable block8");
  endtask

  task automatic t_multi();
    wr(2'd1, 8'h01);
    rd_chk(2'd1, 8'h00, "R6 cross-register reject lower");
    rd_chk(2'd0, 8'h01, "R6 previous kept");
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h03);
    rd_chk(2'd1, 8'h00, "R6 two bits rejected");
    wr(2'd1, 8'h04);
    rd_chk(2'd1, 8'h04, "R6 single bit accepted");
    en_chk(10'h004, "R7 enable block2");
  endtask

  task automatic t_interlock();
    sw_wr_en = 1'b0;
    en_chk(10'h000, "R7 sw enable low gates");
    wr(2'd1, 8'h08);
    sw_wr_en = 1'b1;
    rd_chk(2'd1, 8'h00, "R5 sw low clears and blocks");
    wr(2'd1, 8'h40);
    hw_wr_en = 1'b0;
    idle(1);
    hw_wr_en = 1'b1;
    rd_chk(2'd1, 8'h00, "R5 hw low clears");
    en_chk(10'h000, "R5 enable empty");
  endtask

  task automatic t_standby();
    wr(2'd1, 8'h80);
    hw_standby = 1'b1; idle(1); hw_standby = 1'b0;
    rd_chk(2'd1, 8'h00, "R4 hw standby clears");
    wr(2'd0, 8'h01);
    sw_standby = 1'b1; idle(1); sw_standby = 1'b0;
    rd_chk(2'd0, 8'h00, "R4 sw standby clears");
  endtask

  task automatic t_flash_off();
    wr(2'd1, 8'h20);
    wr(2'd2, 8'h01);
    flash_off = 1'b1;
    rd_chk(2'd1, 8'h20 & 8'h00, "R8 read zero lower");
    rd_chk(2'd2, 8'h00, "R8 read zero control");
    en_chk(10'h000, "R7 flash off gates");
    wr(2'd1, 8'h40);
    wr(2'd2, 8'h00);
    flash_off = 1'b0;
    rd_chk(2'd1, 8'h20, "R8 write ignored");
    chk("R8 setup unchanged", prog_setup, 1'b1);
    en_chk(10'h020, "R7 enable restored");
    wr(2'd2, 8'h00);
  endtask

  task automatic t_setup();
    wr(2'd2, 8'h01);
    chk("R9 set", prog_setup, 1'b1);
    rd_chk(2'd2, 8'h01, "R9 readback");
    wr(2'd2, 8'h00);
    chk("R9 cleared by write", prog_setup, 1'b0);
    sw_wr_en = 1'b0;
    wr(2'd2, 8'h01);
    chk("R9 blocked sw low", prog_setup, 1'b0);
    sw_wr_en = 1'b1;
    wr(2'd2, 8'h01);
    hw_wr_en = 1'b0; idle(1); hw_wr_en = 1'b1;
    chk("R9 cleared hw low", prog_setup, 1'b0);
  endtask

  task automatic t_excl();
    wr(2'd2, 8'h03);
    chk("R10 not set", prog_setup, 1'b0);
    rd_chk(2'd2, 8'h80, "R10 error flag");
    wr(2'd2, 8'h01);
    rd_chk(2'd2, 8'h81, "R11 error sticky");
    wr(2'd2, 8'h41);
    chk("R10 held set", prog_setup, 1'b1);
    wr(2'd2, 8'h80);
    rd_chk(2'd2, 8'h00, "R11 write one clears");
    wr(2'd2, 8'h21);
    wr(2'd2, 8'hA1);
    rd_chk(2'd2, 8'h80, "R11 violation beats clear");
    wr(2'd2, 8'h81);
    rd_chk(2'd2, 8'h01, "R11 clear with setup");
  endtask

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_map();
    t_multi();
    t_interlock();
    t_standby();
    t_flash_off();
    t_setup();
    t_excl();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule